// File: doc/BRIEF.md
# Serial Display Byte Writer

This block pushes command and pixel bytes into a write-only display controller over a four-wire serial link: an active-low select, a serial clock, a serial data line and a line that marks each byte as display data or as a command. Upstream logic offers one byte at a time on a valid/ready handshake, with a flag that says whether the byte is display data (flag high) or a command (flag low). The block sends the byte most significant bit first. It changes data only while the serial clock is low, so the controller can sample each bit on the rising edge.

The serial clock is a fixed division of the system clock. The high and low phases each last `HALF_CYC` system cycles. Two further counts, `CS_SETUP_CYC` and `CS_HOLD_CYC`, space the select edges from the first and last clock edges of a transfer. Elaboration stops with an error if, at the stated system clock period, the parameters would break the minimum period, phase width, data setup and hold, or select setup and hold. If a new byte is offered exactly when a byte finishes, the select stays low and the next byte follows with no gap.

Top module: `serial_disp_writer`

## Requirements
- R1: After reset the select output is high, the serial clock is low, the data/command output is low and `in_ready` is high.
- R2: The eight bits of a byte appear on `disp_sdo` most significant bit first, one bit for each rising edge of `disp_sclk`.
- R3: A single byte with no follower produces exactly eight rising edges of `disp_sclk` while `disp_cs_n` is low.
- R4: `disp_dc` equals the byte's flag: 1 for display data and 0 for a command. It holds that value at every rising edge of the byte.
- R5: `disp_sdo` and `disp_dc` never change while `disp_sclk` is high, and they never change on the cycle in which it rises.
- R6: Each high phase and each low phase of `disp_sclk` within a transfer lasts exactly `HALF_CYC` system clock cycles.
- R7: The first rising edge of `disp_sclk` comes exactly `CS_SETUP_CYC` cycles after `disp_cs_n` falls. The serial clock never rises while the select is high.
- R8: `disp_cs_n` rises exactly `HALF_CYC + CS_HOLD_CYC` cycles after the last rising edge of `disp_sclk`, and only after the clock has been low for at least one cycle.
- R9: A byte offered while `in_ready` is high at the end of a byte is sent under the same select-low window. The low phase between the two bytes lasts exactly `HALF_CYC` cycles.
- R10: A byte is taken only on a cycle where both `in_valid` and `in_ready` are high. During a transfer `in_ready` is low except on the final high-phase cycle, and input values offered while it is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The offered byte is taken at this clock edge |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| in_byte | input | 8 | Byte to send |
| disp_cs_n | output | 1 | Active-low select to the controller |
| disp_sclk | output | 1 | Serial clock, idles low |
| disp_sdo | output | 1 | Serial data, MSB first |
| disp_dc | output | 1 | Data/command marker |

## Verification
The bench measures the select setup and hold intervals and every clock phase in system cycles. A counter that is off by one shows up there as a setup of 1 or 3, or as a hold of 5 or 7. It sends back-to-back bytes of both kinds and checks that the select stays low for all 24 edges and that the flag changes cleanly between bytes. A design that inserted a gap would stretch one low phase, and one that missed the waiting byte would open a second select window. It also moves the input bus while `in_ready` is low, to catch a design that loads or shifts from the live input instead of its own register. Bit-order and flag polarity errors show up as a wrong decoded byte or a wrong data/command level at the sampled edges.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int unsigned BITS_PER_XFER = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD
    } wr_state_t;

    typedef struct packed {
        logic       is_data;
        logic [7:0] value;
    } wr_item_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdw_timer.sv
module sdw_timer #(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdw_shifter.sv
module sdw_shifter
    import sdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  wr_item_t item,
    input  logic     shift,
    output logic     sdo,
    output logic     dc,
    output logic     last
);
    localparam int unsigned BW = $clog2(BITS_PER_XFER);

    logic [BITS_PER_XFER-1:0] sh;
    logic [BW-1:0]            bits_left;
    logic                     dc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            bits_left <= '0;
            dc_q      <= 1'b0;
        end else if (load) begin
            sh        <= item.value;
            dc_q      <= item.is_data;
            bits_left <= BW'(BITS_PER_XFER - 1);
        end else if (shift) begin
            sh        <= {sh[BITS_PER_XFER-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
        end
    end

    assign sdo  = sh[BITS_PER_XFER-1];
    assign dc   = dc_q;
    assign last = (bits_left == '0);
endmodule

// File: rtl/serial_disp_writer.sv
module serial_disp_writer
    import sdw_pkg::*;
#(
    parameter int unsigned SYS_CLK_PS   = 10000,
    parameter int unsigned HALF_CYC     = 5,
    parameter int unsigned CS_SETUP_CYC = 2,
    parameter int unsigned CS_HOLD_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_is_data,
    input  logic [7:0] in_byte,
    output logic       disp_cs_n,
    output logic       disp_sclk,
    output logic       disp_sdo,
    output logic       disp_dc
);
    // Minimum interface times, in picoseconds
    localparam int unsigned MIN_PERIOD_PS = 100000;
    localparam int unsigned MIN_PHASE_PS  = 20000;
    localparam int unsigned MIN_DATA_PS   = 15000;
    localparam int unsigned MIN_CSS_PS    = 20000;
    localparam int unsigned MIN_CSH_PS    = 10000;

    localparam int unsigned CNT_MAX = max3(HALF_CYC, CS_SETUP_CYC, CS_HOLD_CYC);
    localparam int unsigned TW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

    if (2 * HALF_CYC * SYS_CLK_PS < MIN_PERIOD_PS) begin : g_bad_period
        $error("serial clock period below minimum");
    end
    if (HALF_CYC * SYS_CLK_PS < MIN_PHASE_PS || HALF_CYC * SYS_CLK_PS < MIN_DATA_PS) begin : g_bad_phase
        $error("serial clock phase below minimum");
    end
    if (CS_SETUP_CYC == 0 || CS_SETUP_CYC * SYS_CLK_PS < MIN_CSS_PS
        || CS_SETUP_CYC * SYS_CLK_PS < MIN_DATA_PS) begin : g_bad_setup
        $error("select setup below minimum");
    end
    if (CS_HOLD_CYC == 0 || (HALF_CYC + CS_HOLD_CYC) * SYS_CLK_PS < MIN_CSH_PS) begin : g_bad_hold
        $error("select hold below minimum");
    end

    wr_state_t     state, state_n;
    logic          cs_n_q, cs_n_n;
    logic          sclk_q, sclk_n;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_last;
    wr_item_t      item;

    assign item = '{is_data: in_is_data, value: in_byte};

    sdw_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sdw_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .item  (item),
        .shift (sh_shift),
        .sdo   (disp_sdo),
        .dc    (disp_dc),
        .last  (sh_last)
    );

    assign in_ready = (state == ST_IDLE) || (state == ST_HIGH && tmr_done && sh_last);

    always_comb begin
        state_n  = state;
        cs_n_n   = cs_n_q;
        sclk_n   = sclk_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                sh_load  = 1'b1;
                cs_n_n   = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = TW'(CS_SETUP_CYC - 1);
                state_n  = ST_SETUP;
            end
            ST_SETUP, ST_LOW: if (tmr_done) begin
                sclk_n   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(HALF_CYC - 1);
                state_n  = ST_HIGH;
            end
            ST_HIGH: if (tmr_done) begin
                sclk_n   = 1'b0;
                tmr_load = 1'b1;
                if (!sh_last) begin
                    sh_shift = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                    state_n  = ST_LOW;
                end else if (in_valid) begin
                    sh_load  = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                    state_n  = ST_LOW;
                end else begin
                    tmr_val  = TW'(CS_HOLD_CYC - 1);
                    state_n  = ST_HOLD;
                end
            end
            ST_HOLD: if (tmr_done) begin
                cs_n_n  = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            state  <= state_n;
            cs_n_q <= cs_n_n;
            sclk_q <= sclk_n;
        end
    end

    assign disp_cs_n = cs_n_q;
    assign disp_sclk = sclk_q;

    a_r5_lines_stable_while_high: assert property (@(posedge clk) disable iff (rst)
        (!disp_cs_n && disp_sclk) |-> ($stable(disp_sdo) && $stable(disp_dc)));

    a_r7_no_clock_while_deselected: assert property (@(posedge clk) disable iff (rst)
        disp_cs_n |-> !disp_sclk);

    a_r7_rise_after_select: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_sclk) |-> (!disp_cs_n && $past(!disp_cs_n)));

    a_r8_release_after_low_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_cs_n) |-> (!disp_sclk && $past(!disp_sclk)));

    a_r10_ready_only_at_byte_end: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !disp_cs_n) |-> disp_sclk);

endmodule

// File: tb/sim_serial_disp_writer.sv
module sim_serial_disp_writer;
    localparam int HALF = 5;
    localparam int SETUP = 2;
    localparam int HOLD = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_is_data = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       disp_cs_n, disp_sclk, disp_sdo, disp_dc;

    always #5 clk = ~clk;

    serial_disp_writer #(.SYS_CLK_PS(10000), .HALF_CYC(HALF),
                         .CS_SETUP_CYC(SETUP), .CS_HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_data(in_is_data), .in_byte(in_byte), .disp_cs_n(disp_cs_n),
        .disp_sclk(disp_sclk), .disp_sdo(disp_sdo), .disp_dc(disp_dc));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: samples on the falling system clock edge
    logic       clr = 1'b0;
    int         cyc, cs_fall, last_rise, sessions, rises, nbytes, bitn;
    int         setup_meas, hold_meas, run;
    int         hi_min, hi_max, lo_min, lo_max, dc_err;
    logic [7:0] acc;
    logic       got_rise, dc_first, prev_sclk, prev_cs;
    logic [7:0] rx_byte [0:15];
    logic       rx_dc   [0:15];

    always @(negedge clk) begin
        if (clr || rst) begin
            cyc = 0; sessions = 0; rises = 0; nbytes = 0; bitn = 0;
            setup_meas = -1; hold_meas = -1; run = 0; dc_err = 0;
            hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
            got_rise = 1'b0; prev_sclk = disp_sclk; prev_cs = disp_cs_n;
            cs_fall = 0; last_rise = 0; acc = 8'h00; dc_first = 1'b0;
        end else begin
            cyc++;
            if (prev_cs && !disp_cs_n) begin
                cs_fall = cyc; sessions++; got_rise = 1'b0;
            end
            if (disp_sclk == prev_sclk) run++;
            else begin
                if (prev_sclk) begin
                    if (run < hi_min) hi_min = run;
                    if (run > hi_max) hi_max = run;
                end else if (got_rise) begin
                    if (run < lo_min) lo_min = run;
                    if (run > lo_max) lo_max = run;
                end
                run = 1;
            end
            if (!prev_sclk && disp_sclk) begin
                rises++;
                if (!got_rise) setup_meas = cyc - cs_fall;
                got_rise = 1'b1;
                last_rise = cyc;
                if (bitn == 0) dc_first = disp_dc;
                else if (disp_dc != dc_first) dc_err++;
                acc = {acc[6:0], disp_sdo};
                bitn++;
                if (bitn == 8) begin
                    if (nbytes < 16) begin
                        rx_byte[nbytes] = acc;
                        rx_dc[nbytes] = dc_first;
                    end
                    nbytes++;
                    bitn = 0;
                end
            end
            if (!prev_cs && disp_cs_n) hold_meas = cyc - last_rise;
            prev_sclk = disp_sclk;
            prev_cs = disp_cs_n;
        end
    end

    task automatic clear_log();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic push(input logic flag, input logic [7:0] b);
        in_valid = 1'b1; in_is_data = flag; in_byte = b;
        forever begin
            if (in_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!disp_cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(disp_cs_n == 1'b1, "R1 cs_n", disp_cs_n, 1);
        chk(disp_sclk == 1'b0, "R1 sclk", disp_sclk, 0);
        chk(disp_dc == 1'b0, "R1 dc", disp_dc, 0);
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    endtask

    task automatic t_single_data();
        clear_log();
        push(1'b1, 8'hA5); in_valid = 1'b0;
        wait_idle();
        chk(nbytes == 1, "R3 byte count", nbytes, 1);
        chk(rises == 8, "R3 rising edges", rises, 8);
        chk(rx_byte[0] == 8'hA5, "R2 msb-first value", rx_byte[0], 8'hA5);
        chk(rx_dc[0] == 1'b1 && dc_err == 0, "R4 data flag", rx_dc[0], 1);
    endtask

    task automatic t_command_timing();
        clear_log();
        push(1'b0, 8'h3C); in_valid = 1'b0;
        wait_idle();
        chk(rx_byte[0] == 8'h3C, "R2 command value", rx_byte[0], 8'h3C);
        chk(rx_dc[0] == 1'b0 && dc_err == 0, "R4 command flag", rx_dc[0], 0);
        chk(hi_min == HALF && hi_max == HALF, "R6 high phase", hi_max, HALF);
        chk(lo_min == HALF && lo_max == HALF, "R6 low phase", lo_max, HALF);
        chk(setup_meas == SETUP, "R7 select setup", setup_meas, SETUP);
        chk(hold_meas == HALF + HOLD, "R8 select hold", hold_meas, HALF + HOLD);
    endtask

    task automatic t_burst();
        clear_log();
        push(1'b0, 8'h81);
        push(1'b1, 8'h7E);
        push(1'b1, 8'h01);
        in_valid = 1'b0;
        wait_idle();
        chk(sessions == 1, "R9 one select window", sessions, 1);
        chk(rises == 24, "R9 edge count", rises, 24);
        chk(rx_byte[0] == 8'h81 && rx_dc[0] == 1'b0, "R9 byte0", rx_byte[0], 8'h81);
        chk(rx_byte[1] == 8'h7E && rx_dc[1] == 1'b1, "R9 byte1", rx_byte[1], 8'h7E);
        chk(rx_byte[2] == 8'h01 && rx_dc[2] == 1'b1, "R9 byte2", rx_byte[2], 8'h01);
        chk(dc_err == 0, "R4 flag stable per byte", dc_err, 0);
        chk(lo_max == HALF && lo_min == HALF, "R9 no gap", lo_max, HALF);
    endtask

    task automatic t_ignore();
        int ready_mid;
        ready_mid = 0;
        clear_log();
        push(1'b1, 8'hC3); in_valid = 1'b0;
        for (int i = 0; i < 30; i++) begin
            in_byte = 8'(i * 37); in_is_data = i[0];
            if (in_ready && !disp_sclk) ready_mid++;
            @(negedge clk);
        end
        wait_idle();
        chk(ready_mid == 0, "R10 ready low mid-transfer", ready_mid, 0);
        chk(nbytes == 1, "R10 nothing extra taken", nbytes, 1);
        chk(rx_byte[0] == 8'hC3 && rx_dc[0] == 1'b1, "R10 input change ignored", rx_byte[0], 8'hC3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_single_data();
        t_command_timing();
        t_burst();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule